// File: doc/BRIEF.md
# Fractional Pixel Clock Generator

This block derives a display pixel clock from a faster source clock in two stages. The first stage divides the source by a mixed number, an integer N plus a fraction b/a. It makes most periods N source cycles long and stretches some of them by one cycle, so that the long-run average period is exactly N + b/a. The second stage divides this intermediate rate by a whole number P from 1 to 64. P = 1 takes a dedicated pass-through path.

The block drives a pixel clock waveform and a one-cycle tick in the source domain. The tick flags the cycle just before the pixel clock edge on which the interface launches data, either the rising or the falling edge. Outside a transfer, or while the enable is low, the pixel clock rests at a programmed idle level and no ticks appear. Divider settings are sampled at the start of each pixel period and held until that period ends, so a change made mid-period never cuts a pulse short.

Top module: `pixclk_gen`

## Requirements
- R1: While enabled and running with 2 <= N <= 255, every intermediate period lasts either N or N+1 source cycles.
- R2: An integer field value of 0 selects a divisor of 256: with P = 1 and no fraction, every pixel period is 256 source cycles, of which the first 128 are high.
- R3: When 0 < b < a, the number of stretched intermediate periods over any run of M periods is within one of M*b/a. When a = 0 or b >= a, the fraction is ignored and no period is stretched.
- R4: With the pass-through flag clear and a count field c in 1..63, one pixel period spans c+1 intermediate periods. Over K pixel periods the total length L satisfies |L*a - K*(c+1)*(N*a+b)| < a. No pixel period exceeds 257*64 source cycles.
- R5: When the pass-through flag is set, or the count field is 0, one pixel period equals one intermediate period.
- R6: Each pixel period starts high. In pass-through it stays high for floor(len/2) source cycles, where len is the intermediate period length. Otherwise it stays high for the first floor(P/2) intermediate periods.
- R7: While the run input is low, the pixel clock equals the idle level and the tick stays low. This includes the state right after reset.
- R8: While the enable input is low, the pixel clock equals the idle level and the tick stays low, whatever the run input is.
- R9: With edge select 0, the tick is high exactly in the cycles after which the pixel clock rises. With edge select 1, it is high exactly in the cycles after which the pixel clock falls.
- R10: N, a, b, c and the pass-through flag are captured at the start of a pixel period. A change during the period affects only the following period.
- R11: In the first cycle that enable and run are both high, the pixel clock is high and the count starts from a fresh period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Enable for the whole clock path |
| xfer_run | input | 1 | High while a transfer is in progress |
| div_int | input | 8 | Integer divisor N, 0 means 256 |
| frac_den | input | 6 | Fraction denominator a |
| frac_num | input | 6 | Fraction numerator b |
| psc_cnt | input | 6 | Prescale count c, P = c+1 |
| psc_bypass | input | 1 | Pass-through, P = 1 |
| idle_lvl | input | 1 | Pixel clock level when idle |
| edge_neg | input | 1 | 1: tick before falling edge, 0: before rising edge |
| pclk | output | 1 | Pixel clock waveform |
| pix_tick | output | 1 | One-cycle marker before the selected pixel edge |

## Verification
Random divider settings are drawn with a fixed seed, and the total length of several pixel periods is compared with the exact mixed-number formula. A wrong stretch count, a wrong prescale ratio or a lost fraction each shifts the total by at least one source cycle.

Directed settings cover the remaining cases:
- the 256 encoding;
- a numerator larger than the denominator;
- a zero count without the pass-through flag;
- odd periods, which show the high time;
- a divisor change in mid-period, where the old length must finish first.

Every cycle, the bench compares pixel clock transitions with the tick under both edge selections. Idle behaviour is tried with the run input low, with the enable low, and with both idle levels.

// File: rtl/pcg_pkg.sv
// Shared widths and the captured configuration record of the pixel clock generator.
package pcg_pkg;
    localparam int DIV_W  = 8;   // integer divisor field
    localparam int FRAC_W = 6;   // fraction numerator and denominator
    localparam int PSC_W  = 6;   // prescale count field

    typedef struct packed {
        logic [DIV_W-1:0]  n_int;
        logic [FRAC_W-1:0] den;
        logic [FRAC_W-1:0] num;
        logic [PSC_W-1:0]  cnt;
        logic              byp;
    } pcg_cfg_t;
endpackage

// File: rtl/pcg_frac_div.sv
// Fractional divider: produces intermediate periods of N or N+1 source cycles,
// averaging N + num/den, with an accumulator that carries the fraction.
// Assumes N >= 2 (0 encodes 2**DW) and settings held stable by the caller.
module pcg_frac_div #(
    parameter int DW = 8,
    parameter int FW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [DW-1:0] n_int,
    input  logic [FW-1:0] den,
    input  logic [FW-1:0] num,
    output logic          tick,
    output logic          lvl,
    output logic          fall_nxt
);
    localparam int CW = DW + 1;

    logic [CW-1:0] cyc_q;
    logic          ext_q;
    logic [FW-1:0] acc_q;
    logic [CW-1:0] base, len, half;
    logic [FW:0]   sum, sum_less;
    logic          frac_on, wrap;

    // Period length, half point and fraction carry for the current period.
    always_comb begin
        base     = (n_int == '0) ? CW'(1 << DW) : CW'(n_int);
        len      = base + CW'(ext_q);
        half     = len >> 1;
        frac_on  = (den != '0) && (num < den);
        sum      = {1'b0, acc_q} + {1'b0, num};
        sum_less = sum - {1'b0, den};
        wrap     = frac_on && (sum >= {1'b0, den});
        tick     = (cyc_q == len - CW'(1));
        lvl      = (cyc_q < half);
        fall_nxt = (cyc_q == half - CW'(1));
    end

    // Cycle counter and fraction accumulator, cleared whenever idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            cyc_q <= '0;
            ext_q <= 1'b0;
            acc_q <= '0;
        end else if (tick) begin
            cyc_q <= '0;
            ext_q <= wrap;
            acc_q <= !frac_on ? '0 : (wrap ? sum_less[FW-1:0] : sum[FW-1:0]);
        end else begin
            cyc_q <= cyc_q + CW'(1);
        end
    end
endmodule

// File: rtl/pcg_prescale.sv
// Integer prescaler: groups cnt+1 intermediate periods into one pixel period,
// or passes the intermediate waveform through when bypassed or cnt is zero.
// Assumes settings held stable for a whole pixel period by the caller.
module pcg_prescale #(
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          div_tick,
    input  logic          div_lvl,
    input  logic          div_fall,
    input  logic [PW-1:0] cnt,
    input  logic          byp,
    output logic          lvl,
    output logic          rise_nxt,
    output logic          fall_nxt
);
    localparam int PCW = PW + 1;

    logic [PW-1:0]  pc_q;
    logic [PCW-1:0] half;
    logic           pass, last;

    // Waveform level and edge markers for the current intermediate slot.
    always_comb begin
        pass     = byp || (cnt == '0);
        last     = (pc_q == cnt);
        half     = ({1'b0, cnt} + PCW'(1)) >> 1;
        lvl      = pass ? div_lvl : ({1'b0, pc_q} < half);
        rise_nxt = div_tick && (pass || last);
        fall_nxt = pass ? div_fall : (div_tick && ({1'b0, pc_q} == half - PCW'(1)));
    end

    // Intermediate period counter within the pixel period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en)
            pc_q <= '0;
        else if (div_tick)
            pc_q <= (pass || last) ? '0 : pc_q + PW'(1);
    end
endmodule

// File: rtl/pixclk_gen.sv
// Pixel clock generator top: captures settings per pixel period, chains the
// fractional divider and the prescaler, and gates the output to its idle level.
// Assumes the integer divisor field is never 1.
module pixclk_gen
    import pcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              xfer_run,
    input  logic [DIV_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] frac_den,
    input  logic [FRAC_W-1:0] frac_num,
    input  logic [PSC_W-1:0]  psc_cnt,
    input  logic              psc_bypass,
    input  logic              idle_lvl,
    input  logic              edge_neg,
    output logic              pclk,
    output logic              pix_tick
);
    pcg_cfg_t cfg_in, cfg_q, cfg_eff;
    logic     hold_q, active;
    logic     d_tick, d_lvl, d_fall;
    logic     p_lvl, p_rise, p_fall;

    // Live settings, and the captured copy during a pixel period.
    always_comb begin
        active  = clk_en && xfer_run;
        cfg_in  = '{n_int: div_int, den: frac_den, num: frac_num,
                    cnt: psc_cnt, byp: psc_bypass};
        cfg_eff = hold_q ? cfg_q : cfg_in;
    end

    // Hold the settings until the current pixel period closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            cfg_q  <= '0;
        end else begin
            hold_q <= active && !p_rise;
            cfg_q  <= cfg_eff;
        end
    end

    pcg_frac_div #(.DW(DIV_W), .FW(FRAC_W)) frac_i (
        .clk(clk), .rst_n(rst_n), .run_en(active),
        .n_int(cfg_eff.n_int), .den(cfg_eff.den), .num(cfg_eff.num),
        .tick(d_tick), .lvl(d_lvl), .fall_nxt(d_fall)
    );

    pcg_prescale #(.PW(PSC_W)) psc_i (
        .clk(clk), .rst_n(rst_n), .run_en(active),
        .div_tick(d_tick), .div_lvl(d_lvl), .div_fall(d_fall),
        .cnt(cfg_eff.cnt), .byp(cfg_eff.byp),
        .lvl(p_lvl), .rise_nxt(p_rise), .fall_nxt(p_fall)
    );

    // Output gating and active-edge selection.
    always_comb begin
        pclk     = active ? p_lvl : idle_lvl;
        pix_tick = active && (edge_neg ? p_fall : p_rise);
    end
endmodule

// File: rtl/pixclk_gen_chk.sv
// Checker for pixclk_gen: idle gating, tick/edge pairing, start level and a
// bound on the pixel period, all observed at the ports.
module pixclk_gen_chk
    import pcg_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic clk_en,
    input logic xfer_run,
    input logic idle_lvl,
    input logic edge_neg,
    input logic pclk,
    input logic pix_tick
);
    localparam int MAX_GAP = ((1 << DIV_W) + 1) * (1 << PSC_W);
    localparam int GW      = $clog2(MAX_GAP + 1);

    logic          pclk_d;
    logic [GW-1:0] gap_q;
    logic          act;

    assign act = clk_en && xfer_run;

    // Cycles since the last rising pixel edge while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pclk_d <= 1'b0;
            gap_q  <= '0;
        end else begin
            pclk_d <= pclk;
            if (!act || (pclk && !pclk_d))
                gap_q <= '0;
            else if (gap_q != GW'(MAX_GAP))
                gap_q <= gap_q + GW'(1);
        end
    end

    p_idle_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_run |-> (pclk == idle_lvl) && !pix_tick);

    p_idle_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> (pclk == idle_lvl) && !pix_tick);

    p_tick_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_tick && !edge_neg) |=> (!(clk_en && xfer_run) || (pclk && !$past(pclk))));

    p_tick_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_tick && edge_neg) |=> (!(clk_en && xfer_run) || (!pclk && $past(pclk))));

    p_start_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en && xfer_run) |-> pclk);

    p_period_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q < GW'(MAX_GAP));
endmodule

bind pixclk_gen pixclk_gen_chk chk_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .xfer_run(xfer_run),
    .idle_lvl(idle_lvl), .edge_neg(edge_neg), .pclk(pclk), .pix_tick(pix_tick)
);

// File: tb/pixclk_gen_tb_top.sv
// Self-checking bench for pixclk_gen: random and directed divider settings.
module pixclk_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic       xfer_run = 1'b0;
    logic [7:0] div_int = 8'd4;
    logic [5:0] frac_den = '0;
    logic [5:0] frac_num = '0;
    logic [5:0] psc_cnt = '0;
    logic       psc_bypass = 1'b1;
    logic       idle_lvl = 1'b1;
    logic       edge_neg = 1'b0;
    logic       pclk, pix_tick;

    int vecs = 0, errs = 0, cyc = 0;
    int rise_cnt = 0, last_rise = 0, last_period = 0, last_high = 0, hi_cnt = 0;
    int ticks_p = 0, ticks_n = 0;
    bit have_rise = 0, done = 0;
    bit prev_act = 0, prev_pclk = 0, prev_tick = 0, prev_eneg = 0;

    always #5 clk = ~clk;

    pixclk_gen dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .xfer_run(xfer_run),
        .div_int(div_int), .frac_den(frac_den), .frac_num(frac_num),
        .psc_cnt(psc_cnt), .psc_bypass(psc_bypass), .idle_lvl(idle_lvl),
        .edge_neg(edge_neg), .pclk(pclk), .pix_tick(pix_tick)
    );

    task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic bit span_ok(input longint total, input int k, input int n,
                                   input int a, input int b, input int p);
        longint lhs, rhs, d;
        int bf;
        int aa;
        bf  = (a != 0 && b < a) ? b : 0;
        aa  = (a != 0 && b < a) ? a : 1;
        lhs = total * aa;
        rhs = longint'(k) * p * (longint'(n) * aa + bf);
        d   = lhs - rhs;
        if (d < 0) d = -d;
        return d < aa;
    endfunction

    // One cycle: sample at the falling edge and run the per-cycle checks.
    task automatic step();
        bit act, rose, fell;
        @(negedge clk);
        cyc++;
        act  = clk_en && xfer_run;
        rose = pclk && !prev_pclk;
        fell = !pclk && prev_pclk;
        if (!act) begin
            if (!clk_en) chk(pclk == idle_lvl && !pix_tick, "R8 idle while disabled", pclk, idle_lvl);
            else         chk(pclk == idle_lvl && !pix_tick, "R7 idle while not running", pclk, idle_lvl);
            have_rise = 0;
        end else if (prev_act) begin
            if (prev_eneg) chk(fell == prev_tick, "R9 tick vs falling edge", fell, prev_tick);
            else           chk(rose == prev_tick, "R9 tick vs rising edge", rose, prev_tick);
            if (rose) begin
                if (have_rise) begin
                    last_period = cyc - last_rise;
                    last_high   = hi_cnt;
                end
                have_rise = 1;
                last_rise = cyc;
                hi_cnt    = 1;
                rise_cnt++;
            end else if (pclk) begin
                hi_cnt++;
            end
        end
        if (act && pix_tick) begin
            if (edge_neg) ticks_n++;
            else          ticks_p++;
        end
        prev_act  = act;
        prev_pclk = pclk;
        prev_tick = pix_tick;
        prev_eneg = edge_neg;
    endtask

    task automatic wait_rises(input int k);
        int target;
        int guard;
        target = rise_cnt + k;
        guard  = 0;
        while (rise_cnt < target && guard < 40000) begin
            step();
            guard++;
        end
        if (rise_cnt < target) chk(0, "R4 pixel edge missing", rise_cnt, target);
    endtask

    task automatic setup(input int n, input int a, input int b, input int c,
                         input bit byp, input bit eneg, input bit idl);
        xfer_run = 1'b0;
        step();
        div_int = 8'(n); frac_den = 6'(a); frac_num = 6'(b);
        psc_cnt = 6'(c); psc_bypass = byp; edge_neg = eneg; idle_lvl = idl;
        clk_en = 1'b1; xfer_run = 1'b1;
        step();
    endtask

    task automatic measure(input int k, output int total);
        int t0;
        wait_rises(1);
        t0 = last_rise;
        wait_rises(k);
        total = last_rise - t0;
    endtask

    initial begin
        int total;
        int unsigned seed;
        seed = $urandom(32'd13579);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk(pclk == 1'b1 && !pix_tick, "R7 reset state", pclk, 1);

        // R2: zero integer field means 256
        setup(0, 0, 0, 0, 1, 0, 0);
        measure(1, total);
        chk(total == 256, "R2 period with N field 0", total, 256);
        chk(last_high == 128, "R2 high time with N field 0", last_high, 128);

        // R3: numerator not below denominator leaves the fraction unused
        setup(4, 3, 5, 0, 1, 1, 1);
        measure(5, total);
        chk(total == 20, "R3 fraction ignored when b >= a", total, 20);

        // R3: fraction 1/4 on N = 3
        setup(3, 4, 1, 0, 1, 0, 0);
        measure(8, total);
        chk(span_ok(total, 8, 3, 4, 1, 1), "R3 fraction 1/4 average", total, 26);

        // R5: count zero without the flag behaves as pass-through
        setup(6, 0, 0, 0, 0, 0, 1);
        measure(3, total);
        chk(total == 18, "R5 count zero pass-through", total, 18);

        // R6: duty with prescale 3 and with odd pass-through period
        setup(4, 0, 0, 2, 0, 1, 0);
        measure(1, total);
        chk(total == 12, "R4 prescale 3 on N=4", total, 12);
        chk(last_high == 4, "R6 high time with prescale 3", last_high, 4);
        setup(5, 0, 0, 0, 1, 0, 0);
        measure(1, total);
        chk(last_high == 2, "R6 high time odd pass-through", last_high, 2);

        // R11: start level, then immediate return to idle
        xfer_run = 1'b0; idle_lvl = 1'b0;
        step();
        xfer_run = 1'b1;
        #1 chk(pclk == 1'b1, "R11 high at start", pclk, 1);
        step();
        xfer_run = 1'b0;
        #1 chk(pclk == 1'b0, "R7 idle on stop", pclk, 0);

        // R10: divisor change mid-period applies from the next period
        setup(3, 0, 0, 3, 0, 0, 0);
        wait_rises(1);
        repeat (5) step();
        div_int = 8'd5;
        wait_rises(1);
        chk(last_period == 12, "R10 current period keeps old setting", last_period, 12);
        wait_rises(1);
        chk(last_period == 20, "R10 next period uses new setting", last_period, 20);

        // R8: enable low overrides run
        clk_en = 1'b0; idle_lvl = 1'b1;
        repeat (10) step();
        chk(pclk == 1'b1 && !pix_tick, "R8 disabled output", pclk, 1);
        clk_en = 1'b1;

        // R1, R3, R4: random settings against the mixed-number formula
        for (int i = 0; i < 14; i++) begin
            int n, a, b, c, p;
            bit byp;
            n   = 2 + int'($urandom % 14);
            a   = 1 + int'($urandom % 63);
            b   = int'($urandom % 64);
            c   = int'($urandom % 6);
            byp = 1'($urandom % 2);
            p   = (byp || c == 0) ? 1 : c + 1;
            setup(n, a, b, c, byp, 1'($urandom % 2), 1'($urandom % 2));
            measure(6, total);
            chk(span_ok(total, 6, n, a, b, p), "R1 R4 average pixel period", total,
                longint'(6) * p * n);
        end

        chk(ticks_p > 0, "R9 rising-edge ticks seen", ticks_p, 1);
        chk(ticks_n > 0, "R9 falling-edge ticks seen", ticks_n, 1);
        xfer_run = 1'b0;
        step();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule